// File: doc/BRIEF.md
# Scanline IRQ Counter

This block raises a level interrupt to the CPU after a programmed number of rendered video lines. Software writes a value into a reload latch, copies it into the down-counter, and arms or disarms the interrupt through four decoded write strobes that share one data bus. A one-cycle line pulse arrives with the current line number and a rendering-enabled flag. A pulse counts only when the line lies in the visible range and rendering is on. On each such pulse a nonzero counter steps down by one.

When a counted pulse takes the counter from one to zero while the interrupt is armed, the IRQ output asserts. It then holds until software disarms the interrupt. Two details shape the reload path. First, the latch carries a pending mark, and arming the interrupt copies a pending latch into the counter. Second, a latch write that follows a disarm write, with no line pulse in between, loads the counter at once.

The control core is a three-state machine. ST_OFF means disarmed. ST_ARMED means armed and waiting. ST_FIRED means the IRQ is asserted. The transitions are:
- arm: ST_OFF to ST_ARMED, on an enable write.
- hit: ST_ARMED to ST_FIRED, when a counted pulse takes the counter from one to zero.
- disarm: ST_ARMED to ST_OFF, on a disable write.
- acknowledge: ST_FIRED to ST_OFF, on a disable write.

Every other combination stays in the current state.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the IRQ is low, the state is ST_OFF, and counter, latch, pending mark and recent-disarm mark are all zero. A zero counter never produces an interrupt.
- R2: A latch write (`wr_latch_i`) stores `wr_data_i` in the latch and sets the pending mark, unless R3 applies.
- R3: A latch write made while the recent-disarm mark is set also loads `wr_data_i` into the counter and clears the pending mark.
- R4: A reload write (`wr_reload_i`) copies the latch into the counter.
- R5: A disable write (`wr_disable_i`) disarms the interrupt, drops the IRQ on the next cycle and sets the recent-disarm mark.
- R6: An enable write (`wr_enable_i`) arms the interrupt. If the pending mark is set, it also copies the latch into the counter.
- R7: A counted pulse decrements a nonzero counter by one and leaves a zero counter at zero. A counted pulse is `line_pulse_i` with `line_num_i` in VIS_FIRST..VIS_LAST (default 0..239) and `render_on_i` high.
- R8: The IRQ rises in the cycle after a counted pulse that takes the counter from 1 to 0 while armed. It does not rise if that pulse happens while disarmed.
- R9: Once high, the IRQ stays high through further pulses and enable writes until a disable write.
- R10: Any write strobe in the same cycle as a line pulse takes effect and the decrement is dropped. If several strobes coincide, enable wins over disable, disable over reload, and reload over latch.
- R11: A pulse that is not counted (line outside the range, or rendering off) leaves the counter unchanged. Every line pulse, counted or not, clears the recent-disarm mark unless a disable write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_latch_i | input | 1 | Latch write strobe |
| wr_reload_i | input | 1 | Counter reload write strobe |
| wr_disable_i | input | 1 | Disarm and acknowledge write strobe |
| wr_enable_i | input | 1 | Arm write strobe |
| wr_data_i | input | CNT_W | Write data |
| line_pulse_i | input | 1 | One-cycle pulse per video line |
| line_num_i | input | LINE_W | Current line number |
| render_on_i | input | 1 | Rendering enabled |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: CNT_W=8, LINE_W=9, visible range 0..239. The 9-bit line number lets the bench drive lines 240..261 as well, so pulses just outside the visible range are exercised next to counted ones. Small latch values keep one-to-zero hits frequent, and the random phase fires write strobes in the same cycle as line pulses. Together these reach the ordering corners of R3, R10 and R11, which are observable only through when the IRQ rises.

// File: rtl/scirq_pkg.sv
`timescale 1ns/1ps
package scirq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } irq_state_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_LATCH   = 3'd1,
        CMD_RELOAD  = 3'd2,
        CMD_DISABLE = 3'd3,
        CMD_ENABLE  = 3'd4
    } cpu_cmd_e;

endpackage

// File: rtl/scirq_cmd_decode.sv
`timescale 1ns/1ps
module scirq_cmd_decode
    import scirq_pkg::*;
(
    input  logic     wr_latch_i,
    input  logic     wr_reload_i,
    input  logic     wr_disable_i,
    input  logic     wr_enable_i,
    output cpu_cmd_e cmd_o
);

    // R10: fixed priority when strobes coincide
    always_comb begin
        if (wr_enable_i)       cmd_o = CMD_ENABLE;
        else if (wr_disable_i) cmd_o = CMD_DISABLE;
        else if (wr_reload_i)  cmd_o = CMD_RELOAD;
        else if (wr_latch_i)   cmd_o = CMD_LATCH;
        else                   cmd_o = CMD_NONE;
    end

endmodule

// File: rtl/scirq_line_qual.sv
`timescale 1ns/1ps
module scirq_line_qual #(
    parameter int LINE_W    = 9,
    parameter int VIS_FIRST = 0,
    parameter int VIS_LAST  = 239
) (
    input  logic              line_pulse_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              render_on_i,
    output logic              tick_o
);

    localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(VIS_FIRST);
    localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(VIS_LAST);

    logic in_range;

    generate
        if (VIS_FIRST == 0) begin : g_from_zero
            assign in_range = (line_num_i <= LAST_L);
        end else begin : g_window
            assign in_range = (line_num_i >= FIRST_L) && (line_num_i <= LAST_L);
        end
    endgenerate

    // R7: a pulse counts only inside the window while rendering
    assign tick_o = line_pulse_i && render_on_i && in_range;

endmodule

// File: rtl/scirq_counter.sv
`timescale 1ns/1ps
module scirq_counter
    import scirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cpu_cmd_e         cmd_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             line_pulse_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             pending_o,
    output logic             recent_o,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, latch_q;
    logic             pending_q, recent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            latch_q   <= '0;
            pending_q <= 1'b0;
            recent_q  <= 1'b0;
        end else begin
            if (line_pulse_i) recent_q <= 1'b0;          // R11
            case (cmd_i)
                CMD_LATCH: begin                          // R2, R3
                    latch_q <= wr_data_i;
                    if (recent_q) begin
                        cnt_q     <= wr_data_i;
                        pending_q <= 1'b0;
                    end else begin
                        pending_q <= 1'b1;
                    end
                end
                CMD_RELOAD:  cnt_q <= latch_q;            // R4
                CMD_DISABLE: recent_q <= 1'b1;            // R5
                CMD_ENABLE:  if (pending_q) cnt_q <= latch_q; // R6
                default: begin                            // R7, R10
                    if (tick_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
                end
            endcase
        end
    end

    assign hit_o     = tick_i && (cmd_i == CMD_NONE) && (cnt_q == ONE);
    assign cnt_o     = cnt_q;
    assign latch_o   = latch_q;
    assign pending_o = pending_q;
    assign recent_o  = recent_q;

endmodule

// File: rtl/scirq_ctrl_fsm.sv
`timescale 1ns/1ps
module scirq_ctrl_fsm
    import scirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cpu_cmd_e   cmd_i,
    input  logic       hit_i,
    output irq_state_e state_o,
    output logic       irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cmd_i == CMD_ENABLE) state_d = ST_ARMED;          // arm
            end
            ST_ARMED: begin
                if (cmd_i == CMD_DISABLE) state_d = ST_OFF;           // disarm
                else if (hit_i)           state_d = ST_FIRED;         // hit
            end
            ST_FIRED: begin
                if (cmd_i == CMD_DISABLE) state_d = ST_OFF;           // acknowledge
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        irq_o   = (state_q == ST_FIRED);
        state_o = state_q;
    end

endmodule

// File: rtl/scanline_irq_counter.sv
`timescale 1ns/1ps
module scanline_irq_counter
    import scirq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int VIS_FIRST = 0,
    parameter int VIS_LAST  = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_latch_i,
    input  logic              wr_reload_i,
    input  logic              wr_disable_i,
    input  logic              wr_enable_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              line_pulse_i,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              render_on_i,
    output logic              irq_o
);

    cpu_cmd_e         cmd;
    logic             tick, hit;
    logic [CNT_W-1:0] cnt_q, latch_q;
    logic             pending_q, recent_q;
    irq_state_e       state_q;

    scirq_cmd_decode u_dec (
        .wr_latch_i   (wr_latch_i),
        .wr_reload_i  (wr_reload_i),
        .wr_disable_i (wr_disable_i),
        .wr_enable_i  (wr_enable_i),
        .cmd_o        (cmd)
    );

    scirq_line_qual #(
        .LINE_W    (LINE_W),
        .VIS_FIRST (VIS_FIRST),
        .VIS_LAST  (VIS_LAST)
    ) u_qual (
        .line_pulse_i (line_pulse_i),
        .line_num_i   (line_num_i),
        .render_on_i  (render_on_i),
        .tick_o       (tick)
    );

    scirq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .wr_data_i    (wr_data_i),
        .line_pulse_i (line_pulse_i),
        .tick_i       (tick),
        .cnt_o        (cnt_q),
        .latch_o      (latch_q),
        .pending_o    (pending_q),
        .recent_o     (recent_q),
        .hit_o        (hit)
    );

    scirq_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .hit_i   (hit),
        .state_o (state_q),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/scanline_irq_counter_chk.sv
`timescale 1ns/1ps
module scanline_irq_counter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_latch_i,
    input logic             wr_reload_i,
    input logic             wr_disable_i,
    input logic             wr_enable_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic             line_pulse_i,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             pending_q,
    input logic             recent_q,
    input logic             irq_o
);

    logic any_wr;
    assign any_wr = wr_latch_i | wr_reload_i | wr_disable_i | wr_enable_i;

    a_r5_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_disable_i |=> !irq_o);

    a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !wr_disable_i |=> irq_o);

    a_r8_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick) && ($past(cnt_q) == CNT_W'(1)));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload_i && !wr_enable_i && !wr_disable_i |=> cnt_q == $past(latch_q));

    a_r3_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch_i && !wr_reload_i && !wr_enable_i && !wr_disable_i && recent_q
        |=> (cnt_q == $past(wr_data_i)) && !pending_q);

    a_r7_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == '0 && !any_wr |=> cnt_q == '0);

    a_r11_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse_i && !tick && !any_wr |=> $stable(cnt_q));

    a_r11_mark_clear: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse_i && !wr_disable_i |=> !recent_q);

endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_latch_i   (wr_latch_i),
    .wr_reload_i  (wr_reload_i),
    .wr_disable_i (wr_disable_i),
    .wr_enable_i  (wr_enable_i),
    .wr_data_i    (wr_data_i),
    .line_pulse_i (line_pulse_i),
    .tick         (tick),
    .cnt_q        (cnt_q),
    .latch_q      (latch_q),
    .pending_q    (pending_q),
    .recent_q     (recent_q),
    .irq_o        (irq_o)
);

// File: tb/scanline_irq_counter_tb.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb;

    localparam int CNT_W  = 8;
    localparam int LINE_W = 9;
    localparam int C_NONE = 0, C_LATCH = 1, C_RELOAD = 2, C_DIS = 3, C_EN = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_latch = 1'b0, wr_reload = 1'b0, wr_disable = 1'b0, wr_enable = 1'b0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              line_pulse = 1'b0;
    logic [LINE_W-1:0] line_num = '0;
    logic              render_on = 1'b0;
    logic              irq;

    int total = 0;
    int bad   = 0;

    // bench reference state, derived from the requirements
    int m_cnt, m_latch;
    bit m_pend, m_rec, m_en, m_irq;

    always #10 clk = ~clk;

    scanline_irq_counter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_latch_i   (wr_latch),
        .wr_reload_i  (wr_reload),
        .wr_disable_i (wr_disable),
        .wr_enable_i  (wr_enable),
        .wr_data_i    (wr_data),
        .line_pulse_i (line_pulse),
        .line_num_i   (line_num),
        .render_on_i  (render_on),
        .irq_o        (irq)
    );

    task automatic expect_bit(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit counted(input bit pulse, input int line, input bit rend);
        return pulse && rend && (line <= 239);
    endfunction

    task automatic model_update(input int code, input int d, input bit pulse,
                                input int line, input bit rend);
        bit old_rec;
        old_rec = m_rec;
        if (pulse) m_rec = 1'b0;
        case (code)
            C_LATCH: begin
                m_latch = d;
                if (old_rec) begin m_cnt = d; m_pend = 1'b0; end
                else m_pend = 1'b1;
            end
            C_RELOAD: m_cnt = m_latch;
            C_DIS: begin m_en = 1'b0; m_irq = 1'b0; m_rec = 1'b1; end
            C_EN: begin m_en = 1'b1; if (m_pend) m_cnt = m_latch; end
            default: begin
                if (counted(pulse, line, rend) && m_cnt != 0) begin
                    if (m_cnt == 1 && m_en) m_irq = 1'b1;
                    m_cnt = m_cnt - 1;
                end
            end
        endcase
    endtask

    task automatic step(input int code, input int d, input bit pulse, input int line,
                        input bit rend, input string req);
        wr_latch   = (code == C_LATCH);
        wr_reload  = (code == C_RELOAD);
        wr_disable = (code == C_DIS);
        wr_enable  = (code == C_EN);
        wr_data    = CNT_W'(d);
        line_pulse = pulse;
        line_num   = LINE_W'(line);
        render_on  = rend;
        @(posedge clk);
        model_update(code, d, pulse, line, rend);
        @(negedge clk);
        wr_latch = 1'b0; wr_reload = 1'b0; wr_disable = 1'b0; wr_enable = 1'b0;
        line_pulse = 1'b0;
        expect_bit(irq, m_irq, req);
    endtask

    task automatic wr(input int code, input int d, input string req);
        step(code, d, 1'b0, 0, 1'b1, req);
    endtask

    task automatic pl(input int line, input bit rend, input string req);
        step(C_NONE, 0, 1'b1, line, rend, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_cnt = 0; m_latch = 0; m_pend = 0; m_rec = 0; m_en = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_bit(irq, 1'b0, "R1 reset");

        // R1: zero counter never fires
        wr(C_EN, 0, "R1");
        for (int i = 0; i < 4; i++) pl(10 + i, 1'b1, "R1");
        expect_bit(irq, 1'b0, "R1 zero counter");
        wr(C_DIS, 0, "R5");

        // R2, R4, R8, R9, R5
        pl(5, 1'b1, "R11");
        wr(C_LATCH, 3, "R2");
        wr(C_RELOAD, 0, "R4");
        wr(C_EN, 0, "R6");
        pl(20, 1'b1, "R8"); pl(21, 1'b1, "R8");
        expect_bit(irq, 1'b0, "R8 before hit");
        pl(22, 1'b1, "R8");
        expect_bit(irq, 1'b1, "R8 hit");
        pl(23, 1'b1, "R9"); wr(C_EN, 0, "R9"); pl(24, 1'b1, "R9");
        expect_bit(irq, 1'b1, "R9 held");
        wr(C_DIS, 0, "R5");
        expect_bit(irq, 1'b0, "R5 acknowledge");

        // R3: latch right after disarm loads counter directly
        wr(C_LATCH, 2, "R3");
        pl(30, 1'b1, "R3");
        wr(C_EN, 0, "R3");
        pl(31, 1'b1, "R3");
        expect_bit(irq, 1'b1, "R3 direct load");
        wr(C_DIS, 0, "R5");

        // R11 clearing of the mark by an uncounted pulse, R6 reload on arm
        wr(C_LATCH, 4, "R3");
        wr(C_DIS, 0, "R5");
        pl(250, 1'b1, "R11");
        wr(C_LATCH, 2, "R2");
        pl(40, 1'b1, "R11");
        wr(C_EN, 0, "R6");
        pl(41, 1'b1, "R11");
        expect_bit(irq, 1'b0, "R11 mark cleared");
        pl(42, 1'b1, "R6");
        expect_bit(irq, 1'b1, "R6 pending reload");
        wr(C_DIS, 0, "R5");

        // R11: uncounted pulses leave the counter alone
        wr(C_LATCH, 1, "R3");
        pl(50, 1'b0, "R11"); pl(240, 1'b1, "R11"); pl(261, 1'b1, "R11");
        wr(C_EN, 0, "R11");
        expect_bit(irq, 1'b0, "R11 before count");
        pl(239, 1'b1, "R7");
        expect_bit(irq, 1'b1, "R7 last visible line counts");
        wr(C_DIS, 0, "R5");

        // R8: hit while disarmed does not fire later
        wr(C_LATCH, 1, "R3");
        pl(60, 1'b1, "R8");
        wr(C_EN, 0, "R8");
        for (int i = 0; i < 3; i++) pl(61 + i, 1'b1, "R8");
        expect_bit(irq, 1'b0, "R8 disarmed hit");
        wr(C_DIS, 0, "R5");

        // R10: write wins over a coincident pulse
        wr(C_LATCH, 2, "R3");
        wr(C_EN, 0, "R10");
        step(C_RELOAD, 0, 1'b1, 70, 1'b1, "R10");
        pl(71, 1'b1, "R10");
        expect_bit(irq, 1'b0, "R10 decrement dropped");
        pl(72, 1'b1, "R10");
        expect_bit(irq, 1'b1, "R10 hit");
        step(C_DIS, 0, 1'b1, 73, 1'b1, "R10");
        wr(C_LATCH, 1, "R10");
        wr(C_EN, 0, "R10");
        pl(74, 1'b1, "R10");
        expect_bit(irq, 1'b1, "R10 disarm beats pulse on mark");
        wr(C_DIS, 0, "R5");

        // random phase with fixed seed
        void'($urandom(32'd4939));
        for (int n = 0; n < 4000; n++) begin
            int r, code, d, line;
            bit p, rend;
            r = $urandom_range(0, 99);
            if (r < 8)       code = C_LATCH;
            else if (r < 12) code = C_RELOAD;
            else if (r < 17) code = C_DIS;
            else if (r < 22) code = C_EN;
            else             code = C_NONE;
            d    = $urandom_range(0, 5);
            p    = ($urandom_range(0, 9) < 6);
            line = $urandom_range(0, 261);
            rend = ($urandom_range(0, 19) < 17);
            step(code, d, p, line, rend, "R7 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule